// File: doc/BRIEF.md
# Shadow Stack Page Permission Checker

This block decides, for one memory access at a time, whether the access may proceed or which fault it must raise. It looks at the kind of access (an ordinary load or store, or one of the three shadow-stack operations), the leaf page-table-entry permission bits, the physical-memory-protection read and write grants, whether the target region has side effects on access, whether translation is off, the effective privilege, and the two environment enables for shadow stacks. The page-table walk has already happened upstream. This block only classifies the result.

A page whose entry has read clear, write set and execute clear counts as a shadow-stack page, as long as shadow stacks are enabled for the current context. Shadow-stack operations may only touch such pages, and ordinary stores may not. A mismatch between the page kind and the access kind gives an access fault, never a page fault. Page faults are kept for encodings that are invalid or reserved.

Requests come in on a valid/ready stream and verdicts go out on another, one register stage apart. A request is accepted on a clock edge where both `i_valid` and `i_ready` are high. `i_ready` is high whenever the output register is empty or is being drained in that same cycle, so a stalled consumer holds the verdict steady and blocks new requests. The input side has no buffering beyond that single register.

Top module: `ss_perm_check`

## Requirements
- R1: A request accepted on a clock edge (`i_valid` and `i_ready` both high) appears at the next edge with `o_valid` high and its verdict on `o_verdict`. `i_ready` equals `!o_valid || o_ready`. While `o_valid` is high and `o_ready` is low, both `o_valid` and `o_verdict` hold.
- R2: After reset, `o_valid` is low and `i_ready` is high.
- R3: `i_kind` encodes the access: 0 is an ordinary load, 1 an ordinary store, 2 a shadow pop-and-check, 3 a shadow push, 4 a shadow swap, and 5 to 7 are treated as an ordinary load. `o_verdict` encodes the result: 0 allow, 1 page fault, 2 load access fault, 3 store/AMO access fault. A write-type access is a store, push or swap. The matching access fault of a write-type access is 3, and that of any other access is 2. An access that meets none of the fault rules is allowed.
- R4: When translation is on (`i_bare`=0), the behaviour of the encoding R=0, W=1, X=0 depends on whether shadow stacks are enabled for the current context.
  - Shadow stacks are enabled when `i_menv_ss`=1 and either `i_virt`=0 or `i_henv_ss`=1. In that case the encoding marks a shadow-stack page.
  - Otherwise the encoding is reserved and gives a page fault.
  - The encoding R=0, W=1, X=1 always gives a page fault.
- R5: With translation on, ordinary accesses are checked as follows.
  - An ordinary load is permitted on a page with R=1 or on a shadow-stack page. On any other page it gives a page fault.
  - An ordinary store needs R=1 and W=1, otherwise it gives a page fault.
  - An ordinary store to a shadow-stack page gives a store/AMO access fault.
- R6: With translation on, a shadow access to a page that is not a shadow-stack page gives its matching access fault. Pop-and-check gives a load access fault, and push and swap give a store/AMO access fault.
- R7: With translation off (`i_bare`=1), the PTE inputs are ignored and no page fault is raised. At privilege below machine level (`i_priv` not equal to 3), every shadow access gives its matching access fault.
- R8: A write-type access without `i_pmp_w` gives a store/AMO access fault. Any other access without `i_pmp_r` gives a load access fault.
- R9: A shadow access to a region with side effects (`i_noidem`=1) gives its matching access fault.
- R10: When several rules apply at once, a page fault is reported ahead of any access fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| i_valid | input | 1 | Request valid |
| i_ready | output | 1 | Request accepted when high together with i_valid |
| i_kind | input | 3 | Access kind code (R3) |
| i_pte_r | input | 1 | Leaf entry read bit |
| i_pte_w | input | 1 | Leaf entry write bit |
| i_pte_x | input | 1 | Leaf entry execute bit |
| i_pmp_r | input | 1 | Protection region grants read |
| i_pmp_w | input | 1 | Protection region grants write |
| i_menv_ss | input | 1 | Machine-level shadow-stack enable |
| i_henv_ss | input | 1 | Hypervisor-level shadow-stack enable for guests |
| i_virt | input | 1 | Access comes from a virtualized guest |
| i_bare | input | 1 | Address translation is off |
| i_noidem | input | 1 | Target region has side effects on access |
| i_priv | input | 2 | Effective privilege, 3 is machine level |
| o_valid | output | 1 | Verdict valid |
| o_ready | input | 1 | Consumer takes the verdict |
| o_verdict | output | 2 | Verdict code (R3) |

## Verification
The only internal state is the single output slot, so a wrong slot state shows up right away at the ports. A lost or doubled verdict shows as a wrong `o_valid`, or a wrong `i_ready` in the same cycle. A verdict overwritten under stall shows as a changed `o_verdict` while `o_ready` is low. A flaw in the classification logic is seen exactly one edge after the request is accepted, as a wrong code: for example, a page fault where an access fault belongs, or a load fault where a store fault belongs. Random stalls on `o_ready` exercise the hold path, and random environment bits exercise the enable cases of the reserved encoding.

// File: rtl/ssck_pkg.sv
package ssck_pkg;
  localparam int KIND_W = 3;
  localparam int PRIV_W = 2;
  localparam int VERD_W = 2;

  localparam logic [KIND_W-1:0] K_LOAD   = 3'd0;
  localparam logic [KIND_W-1:0] K_STORE  = 3'd1;
  localparam logic [KIND_W-1:0] K_SSPOP  = 3'd2;
  localparam logic [KIND_W-1:0] K_SSPUSH = 3'd3;
  localparam logic [KIND_W-1:0] K_SSSWAP = 3'd4;

  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;

  typedef enum logic [VERD_W-1:0] {
    V_ALLOW      = 2'd0,
    V_PAGE_FAULT = 2'd1,
    V_LOAD_ACC   = 2'd2,
    V_STORE_ACC  = 2'd3
  } verdict_e;

  typedef struct packed {
    logic is_ss;
    logic is_write;
  } kind_attr_t;
endpackage

// File: rtl/ssck_kind_decode.sv
module ssck_kind_decode
  import ssck_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output kind_attr_t        attr
);
  always_comb begin
    attr = '0;
    unique case (kind)
      K_STORE:  attr.is_write = 1'b1;
      K_SSPOP:  attr.is_ss    = 1'b1;
      K_SSPUSH: begin attr.is_ss = 1'b1; attr.is_write = 1'b1; end
      K_SSSWAP: begin attr.is_ss = 1'b1; attr.is_write = 1'b1; end
      default:  attr = '0;
    endcase
  end
endmodule

// File: rtl/ssck_page_decode.sv
module ssck_page_decode (
  input  logic pte_r,
  input  logic pte_w,
  input  logic pte_x,
  input  logic menv_ss,
  input  logic henv_ss,
  input  logic virt,
  output logic ss_page,
  output logic rsvd
);
  logic ss_on;
  logic ss_code;
  logic wx_only;

  assign ss_on   = menv_ss & (~virt | henv_ss);
  assign ss_code = ~pte_r & pte_w & ~pte_x;
  assign wx_only = ~pte_r & pte_w &  pte_x;
  assign ss_page = ss_code & ss_on;
  assign rsvd    = wx_only | (ss_code & ~ss_on);
endmodule

// File: rtl/ssck_fault_sel.sv
module ssck_fault_sel
  import ssck_pkg::*;
(
  input  kind_attr_t attr,
  input  logic       ss_page,
  input  logic       rsvd,
  input  logic       pte_r,
  input  logic       pte_w,
  input  logic       bare,
  input  logic       below_m,
  input  logic       pmp_r,
  input  logic       pmp_w,
  input  logic       noidem,
  output verdict_e   verdict
);
  logic perm_pf, pf, kind_af, prot_af;
  verdict_e acc_code;

  always_comb begin
    if (attr.is_ss)         perm_pf = 1'b0;
    else if (attr.is_write) perm_pf = ~(pte_r & pte_w) & ~ss_page;
    else                    perm_pf = ~(pte_r | ss_page);
  end

  assign pf = ~bare & (rsvd | perm_pf);

  always_comb begin
    if (bare) kind_af = attr.is_ss & below_m;
    else      kind_af = (attr.is_ss & ~ss_page) |
                        (~attr.is_ss & attr.is_write & ss_page);
  end

  assign prot_af  = (attr.is_ss & noidem) | (attr.is_write ? ~pmp_w : ~pmp_r);
  assign acc_code = attr.is_write ? V_STORE_ACC : V_LOAD_ACC;

  always_comb begin
    if (pf)                     verdict = V_PAGE_FAULT;
    else if (kind_af | prot_af) verdict = acc_code;
    else                        verdict = V_ALLOW;
  end
endmodule

// File: rtl/ssck_pipe.sv
module ssck_pipe #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic fire;
  assign in_ready = ~out_valid | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ss_perm_check.sv
module ss_perm_check
  import ssck_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  output logic              i_ready,
  input  logic [KIND_W-1:0] i_kind,
  input  logic              i_pte_r,
  input  logic              i_pte_w,
  input  logic              i_pte_x,
  input  logic              i_pmp_r,
  input  logic              i_pmp_w,
  input  logic              i_menv_ss,
  input  logic              i_henv_ss,
  input  logic              i_virt,
  input  logic              i_bare,
  input  logic              i_noidem,
  input  logic [PRIV_W-1:0] i_priv,
  output logic              o_valid,
  input  logic              o_ready,
  output logic [VERD_W-1:0] o_verdict
);
  kind_attr_t attr;
  logic       ss_page, rsvd, below_m;
  verdict_e   verdict;

  assign below_m = (i_priv != PRIV_MACHINE);

  ssck_kind_decode u_kind (
    .kind (i_kind),
    .attr (attr)
  );

  ssck_page_decode u_page (
    .pte_r   (i_pte_r),
    .pte_w   (i_pte_w),
    .pte_x   (i_pte_x),
    .menv_ss (i_menv_ss),
    .henv_ss (i_henv_ss),
    .virt    (i_virt),
    .ss_page (ss_page),
    .rsvd    (rsvd)
  );

  ssck_fault_sel u_sel (
    .attr    (attr),
    .ss_page (ss_page),
    .rsvd    (rsvd),
    .pte_r   (i_pte_r),
    .pte_w   (i_pte_w),
    .bare    (i_bare),
    .below_m (below_m),
    .pmp_r   (i_pmp_r),
    .pmp_w   (i_pmp_w),
    .noidem  (i_noidem),
    .verdict (verdict)
  );

  ssck_pipe #(.W(VERD_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (i_valid),
    .in_ready  (i_ready),
    .in_data   (verdict),
    .out_valid (o_valid),
    .out_ready (o_ready),
    .out_data  (o_verdict)
  );
endmodule

// File: rtl/ss_perm_check_sva.sv
module ss_perm_check_sva
  import ssck_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              i_valid,
  input logic              i_ready,
  input logic [KIND_W-1:0] i_kind,
  input logic              i_pte_r,
  input logic              i_pte_w,
  input logic              i_pte_x,
  input logic              i_menv_ss,
  input logic              i_virt,
  input logic              i_bare,
  input logic              o_valid,
  input logic              o_ready,
  input logic [VERD_W-1:0] o_verdict
);
  logic fire;
  assign fire = i_valid & i_ready;

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> o_valid); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_verdict))); // R1
  AST_BARE_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && i_bare) |=> (o_verdict != V_PAGE_FAULT)); // R7
  AST_WX_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !i_bare && !i_pte_r && i_pte_w && i_pte_x) |=> (o_verdict == V_PAGE_FAULT)); // R4
  AST_POP_NOT_STORE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && i_kind == K_SSPOP) |=> (o_verdict != V_STORE_ACC)); // R6
  AST_PUSH_NOT_LOAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && i_kind == K_SSPUSH) |=> (o_verdict != V_LOAD_ACC)); // R6
  AST_STORE_SS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !i_bare && i_kind == K_STORE && !i_pte_r && i_pte_w && !i_pte_x
     && i_menv_ss && !i_virt) |=> (o_verdict == V_STORE_ACC)); // R5
endmodule

bind ss_perm_check ss_perm_check_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .i_valid   (i_valid),
  .i_ready   (i_ready),
  .i_kind    (i_kind),
  .i_pte_r   (i_pte_r),
  .i_pte_w   (i_pte_w),
  .i_pte_x   (i_pte_x),
  .i_menv_ss (i_menv_ss),
  .i_virt    (i_virt),
  .i_bare    (i_bare),
  .o_valid   (o_valid),
  .o_ready   (o_ready),
  .o_verdict (o_verdict)
);

// File: tb/sim_ss_perm_check.sv
`timescale 1ns/1ps
module sim_ss_perm_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_valid = 1'b0, i_ready;
  logic [2:0] i_kind = '0;
  logic i_pte_r = 0, i_pte_w = 0, i_pte_x = 0, i_pmp_r = 1, i_pmp_w = 1;
  logic i_menv_ss = 0, i_henv_ss = 0, i_virt = 0, i_bare = 0, i_noidem = 0;
  logic [1:0] i_priv = '0;
  logic o_valid, o_ready = 1'b1;
  logic [1:0] o_verdict;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic       ev = 0;
  logic [1:0] everd = '0;
  string      etag = "R2";
  bit         pend_fire = 0, pend_cons = 0;
  logic [1:0] pend_v = '0;
  string      pend_tag = "";

  always #2.5 clk = ~clk;

  ss_perm_check u0 (.*);

  function automatic logic [1:0] model(
    input logic [2:0] k, input logic r, input logic w, input logic x,
    input logic pr, input logic pw, input logic men, input logic hen,
    input logic virt, input logic bare, input logic io, input logic [1:0] priv,
    output string tag);
    bit ss, wr, sson, sspg;
    logic [1:0] acc;
    ss  = (k == 3'd2) || (k == 3'd3) || (k == 3'd4);
    wr  = (k == 3'd1) || (k == 3'd3) || (k == 3'd4);
    acc = wr ? 2'd3 : 2'd2;
    if (!bare) begin
      sson = men && (!virt || hen);
      sspg = !r && w && !x && sson;
      if (!r && w && x)             begin tag = "R4"; return 2'd1; end
      if (!r && w && !x && !sson)   begin tag = "R4"; return 2'd1; end
      if (!ss) begin
        if (wr && !sspg && !(r && w)) begin tag = "R5"; return 2'd1; end
        if (!wr && !r && !sspg)       begin tag = "R5"; return 2'd1; end
        if (wr && sspg)               begin tag = "R5"; return 2'd3; end
      end else if (!sspg)           begin tag = "R6"; return acc; end
    end else if (ss && priv != 2'd3) begin tag = "R7"; return acc; end
    if (ss && io)                   begin tag = "R9"; return acc; end
    if ((wr && !pw) || (!wr && !pr)) begin tag = "R8"; return acc; end
    tag = "R3";
    return 2'd0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] k, input logic r, input logic w, input logic x,
                      input logic pr, input logic pw, input logic men, input logic hen,
                      input logic virt, input logic bare, input logic io,
                      input logic [1:0] priv, input logic vld, input logic rdy);
    @(negedge clk);
    if (pend_fire) begin ev = 1; everd = pend_v; etag = pend_tag; end
    else if (pend_cons) ev = 0;
    check(o_valid == ev, "R1", "o_valid", o_valid, ev);
    if (ev && o_valid) check(o_verdict == everd, etag, "o_verdict", o_verdict, everd);
    i_kind = k; i_pte_r = r; i_pte_w = w; i_pte_x = x; i_pmp_r = pr; i_pmp_w = pw;
    i_menv_ss = men; i_henv_ss = hen; i_virt = virt; i_bare = bare; i_noidem = io;
    i_priv = priv; i_valid = vld; o_ready = rdy;
    #1;
    check(i_ready == (!ev || rdy), "R1", "i_ready", i_ready, (!ev || rdy));
    pend_fire = i_valid && i_ready;
    pend_cons = o_valid && o_ready;
    pend_v = model(k, r, w, x, pr, pw, men, hen, virt, bare, io, priv, pend_tag);
  endtask

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(o_valid == 1'b0, "R2", "o_valid after reset", o_valid, 0);
    check(i_ready == 1'b1, "R2", "i_ready after reset", i_ready, 1);
    // directed corner cases
    step(3'd0, 0,1,0, 1,1, 1,0,0, 0,0, 2'd0, 1,1); // R5 load reads shadow page
    step(3'd1, 0,1,0, 1,1, 1,0,0, 0,0, 2'd0, 1,1); // R5 store to shadow page
    step(3'd3, 0,1,0, 1,1, 1,0,0, 0,0, 2'd1, 1,1); // R3 push allowed
    step(3'd2, 1,1,0, 1,1, 1,0,0, 0,0, 2'd1, 1,1); // R6 pop on normal page
    step(3'd4, 1,1,0, 1,1, 1,0,0, 0,0, 2'd1, 1,1); // R6 swap on normal page
    step(3'd3, 0,1,0, 1,1, 0,1,0, 0,0, 2'd1, 1,1); // R4 reserved, machine enable off
    step(3'd3, 0,1,0, 1,1, 1,0,1, 0,0, 2'd1, 1,1); // R4 guest, hypervisor enable off
    step(3'd3, 0,1,0, 1,1, 1,1,1, 0,0, 2'd1, 1,1); // R4 guest enabled
    step(3'd0, 0,1,1, 0,0, 1,1,0, 0,1, 2'd1, 1,1); // R10 page fault beats PMP
    step(3'd2, 0,1,0, 1,1, 1,0,0, 1,0, 2'd0, 1,1); // R7 bare below M
    step(3'd2, 0,0,0, 1,1, 1,0,0, 1,0, 2'd3, 1,1); // R7 bare at M
    step(3'd3, 0,1,0, 1,0, 1,0,0, 0,0, 2'd1, 1,1); // R8 push no write grant
    step(3'd2, 0,1,0, 0,1, 1,0,0, 0,0, 2'd1, 1,1); // R8 pop no read grant
    step(3'd4, 0,1,0, 1,1, 1,0,0, 0,1, 2'd1, 1,1); // R9 side-effect region
    step(3'd6, 0,0,1, 1,1, 1,0,0, 0,0, 2'd1, 1,1); // R3 code 6 as load, R5 X-only
    step(3'd1, 1,0,0, 1,1, 1,0,0, 0,0, 2'd1, 1,0); // R1 stall begins
    step(3'd0, 1,0,0, 1,1, 1,0,0, 0,0, 2'd1, 1,0); // R1 stall holds
    step(3'd0, 1,0,0, 1,1, 1,0,0, 0,0, 2'd1, 1,1);
    // constrained random with back-pressure
    for (int n = 0; n < 3000; n++) begin
      logic r, w, x;
      if ($urandom_range(0, 9) < 4) begin r = 0; w = 1; x = 0; end
      else begin r = 1'($urandom); w = 1'($urandom); x = 1'($urandom); end
      step(3'($urandom), r, w, x,
           $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0,
           $urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom),
           $urandom_range(0, 4) == 0, $urandom_range(0, 7) == 0,
           2'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
    end
    step(3'd0, 1,0,0, 1,1, 0,0,0, 0,0, 2'd0, 0,1);
    step(3'd0, 1,0,0, 1,1, 0,0,0, 0,0, 2'd0, 0,1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule